// File: doc/BRIEF.md
# Software-Refilled Translation Cache with Pinnable Entries

This block is a small fully associative cache of virtual-to-physical page translations. Software loads it, and software alone: no hardware walks a page table. A lookup presents a 32-bit virtual address and an access kind. In the same cycle the block returns the physical address, raises a miss trap that carries the faulting virtual page number, or raises a protection trap when the cached permission bits forbid the access. Pages are 4 KB, so the low 12 address bits pass straight through to the physical address.

Software talks to the block through a command port. It can install a mapping into a slot chosen by a round-robin pointer, install a mapping at an explicit slot, drop the mapping for one page, or flush the cache on a context switch. Any entry can be pinned with a lock bit. Round-robin replacement skips pinned entries, and a flush leaves them in place. A small state machine runs the commands. In ST_IDLE it accepts any command. A flush moves it to ST_SWEEP (transition IDLE_TO_SWEEP), where it clears one slot per cycle for N cycles. It then returns to ST_IDLE (transition SWEEP_TO_IDLE). While the sweep runs, lookups already treat unpinned entries as absent.

Top module: `soft_tlb`

## Requirements
- R1: After reset every entry is invalid and unpinned, the round-robin pointer is 0, cmd_ready is 1 and wr_err is 0, so every lookup misses.
- R2: A lookup that hits and is permitted sets lk_hit in the same cycle, with lk_paddr equal to the entry's 20-bit frame number concatenated with lk_vaddr[11:0]. When lk_hit is 0, lk_paddr is 0.
- R3: When lk_valid is 1 and no visible entry holds lk_vaddr[31:12], miss_trap is 1 and lk_hit and prot_trap are 0. miss_vpn always equals lk_vaddr[31:12]. When lk_valid is 0, all three flags are 0.
- R4: Permission bits are bit0 read, bit1 write and bit2 execute. lk_acc selects the bit to test: 0 is a load and tests read, 1 is a store and tests write, 2 is a fetch and tests execute, 3 is treated as a load. On a matching entry whose tested bit is 0, prot_trap is 1 and lk_hit is 0.
- R5: Op 0 (auto write) with a page not yet cached writes the first unpinned slot at or after the round-robin pointer, wrapping modulo N. The pointer then moves to that slot plus one, modulo N.
- R6: If every slot is pinned, an auto write of an uncached page changes no entry and sets wr_err. wr_err stays at 1 until a later write command succeeds.
- R7: An auto write whose page already sits in a valid entry overwrites that entry, even a pinned one, and leaves the pointer unchanged. At most one entry ever matches a lookup.
- R8: Op 1 (indexed write) writes slot cmd_idx whether or not that slot is pinned. Any other valid entry holding the same page is invalidated.
- R9: Op 2 (drop) invalidates and unpins the entry holding cmd_vpn, even when it is pinned.
- R10: Op 3 (flush) holds cmd_ready at 0 for exactly N cycles after acceptance. From the first cycle after acceptance, unpinned entries are invisible to lookups. At the end only pinned entries remain.
- R11: A command is accepted only when cmd_valid and cmd_ready are both 1, and its effect becomes visible to lookups in the next cycle. A command offered while cmd_ready is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| lk_hit | output | 1 | Translation found and permitted |
| lk_paddr | output | 32 | Translated physical address |
| miss_trap | output | 1 | No entry for the page; software must refill |
| miss_vpn | output | 20 | Page number of the lookup |
| prot_trap | output | 1 | Entry found but permission bit clear |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 auto write, 1 indexed write, 2 drop, 3 flush |
| cmd_idx | input | 4 | Slot for an indexed write |
| cmd_vpn | input | 20 | Page number of the command |
| cmd_pfn | input | 20 | Frame number to install |
| cmd_perm | input | 3 | Permission bits {X,W,R} to install |
| cmd_lock | input | 1 | Pin the installed entry |
| cmd_ready | output | 1 | Block can accept a command |
| wr_err | output | 1 | Last auto write refused, all slots pinned |

## Verification
The assertions assume that commands are offered only when cmd_ready is 1 or are otherwise meant to be ignored. They also assume that cmd_idx is always below N, which holds whenever N is a power of two. They assume that software never asks the block to hold the same page twice except through the write paths that remove the duplicate. The stimulus drives every command on the falling edge, one at a time. It keeps every indexed slot inside the 16-entry array, and it offers exactly one command during a flush sweep, on purpose, to show that the command is ignored.

// File: rtl/stlb_pkg.sv
package stlb_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = 20;
    localparam int PA_W  = PFN_W + OFF_W;

    typedef enum logic [1:0] {
        OP_WRITE_AUTO = 2'd0,
        OP_WRITE_AT   = 2'd1,
        OP_DROP_ONE   = 2'd2,
        OP_FLUSH      = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } fsm_e;

    typedef struct packed {
        logic             valid;
        logic             lock;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic [2:0]       perm;
    } tlb_ent_t;
endpackage

// File: rtl/stlb_cam.sv
module stlb_cam
    import stlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            valid_vec,
    input  logic [N-1:0][VPN_W-1:0] vpn_vec,
    input  logic [VPN_W-1:0]        key,
    output logic [N-1:0]            hit_vec,
    output logic                    found,
    output logic [IDX_W-1:0]        idx
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g] && (vpn_vec[g] == key);
    end

    assign found = |hit_vec;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/stlb_victim.sv
module stlb_victim #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     lock_vec,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        int j;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            j = int'(rr_ptr) + k;
            if (j >= N) j = j - N;
            if (!found && !lock_vec[j]) begin
                found = 1'b1;
                idx   = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
    import stlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [31:0]      lk_vaddr,
    input  logic [1:0]       lk_acc,
    output logic             lk_hit,
    output logic [31:0]      lk_paddr,
    output logic             miss_trap,
    output logic [19:0]      miss_vpn,
    output logic             prot_trap,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic [19:0]      cmd_vpn,
    input  logic [19:0]      cmd_pfn,
    input  logic [2:0]       cmd_perm,
    input  logic             cmd_lock,
    output logic             cmd_ready,
    output logic             wr_err
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    tlb_ent_t ent_q [N];
    fsm_e     state_q, state_d;
    logic [IDX_W-1:0] rr_q, rr_d, sweep_q;
    logic             err_q, err_d;

    logic [N-1:0]            valid_vec, lock_vec, vis_vec;
    logic [N-1:0][VPN_W-1:0] vpn_vec;

    for (genvar g = 0; g < N; g++) begin : g_vec
        assign valid_vec[g] = ent_q[g].valid;
        assign lock_vec[g]  = ent_q[g].lock;
        assign vpn_vec[g]   = ent_q[g].vpn;
    end

    // during a sweep only pinned entries stay visible
    assign vis_vec = (state_q == ST_SWEEP) ? (valid_vec & lock_vec) : valid_vec;

    // lookup side
    logic [N-1:0]     lk_hits;
    logic             lk_found;
    logic [IDX_W-1:0] lk_idx;

    stlb_cam #(.N(N), .IDX_W(IDX_W)) u_lk_cam (
        .valid_vec(vis_vec), .vpn_vec(vpn_vec), .key(lk_vaddr[VA_W-1:OFF_W]),
        .hit_vec(lk_hits), .found(lk_found), .idx(lk_idx)
    );

    // command side
    logic [N-1:0]     c_hits;
    logic             c_found;
    logic [IDX_W-1:0] c_idx;

    stlb_cam #(.N(N), .IDX_W(IDX_W)) u_cmd_cam (
        .valid_vec(valid_vec), .vpn_vec(vpn_vec), .key(cmd_vpn),
        .hit_vec(c_hits), .found(c_found), .idx(c_idx)
    );

    logic             v_found;
    logic [IDX_W-1:0] v_idx;

    stlb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
        .lock_vec(lock_vec), .rr_ptr(rr_q), .found(v_found), .idx(v_idx)
    );

    // permission test
    logic    perm_ok;
    logic [2:0] sel_perm;
    acc_e    acc;
    assign acc      = acc_e'(lk_acc);
    assign sel_perm = ent_q[lk_idx].perm;

    always_comb begin
        unique case (acc)
            ACC_LOAD:  perm_ok = sel_perm[0];
            ACC_STORE: perm_ok = sel_perm[1];
            ACC_FETCH: perm_ok = sel_perm[2];
            ACC_RSVD:  perm_ok = sel_perm[0];
        endcase
    end

    assign lk_hit    = lk_valid && lk_found && perm_ok;
    assign prot_trap = lk_valid && lk_found && !perm_ok;
    assign miss_trap = lk_valid && !lk_found;
    assign miss_vpn  = lk_vaddr[VA_W-1:OFF_W];
    assign lk_paddr  = lk_hit ? {ent_q[lk_idx].pfn, lk_vaddr[OFF_W-1:0]} : '0;

    // command FSM
    cmd_op_e op;
    logic    take;
    assign op        = cmd_op_e'(cmd_op);
    assign cmd_ready = (state_q == ST_IDLE);
    assign take      = cmd_valid && cmd_ready;
    assign wr_err    = err_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take && op == OP_FLUSH) state_d = ST_SWEEP;
            ST_SWEEP: if (sweep_q == LAST) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // array update decisions
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [N-1:0]     clr_vec;
    tlb_ent_t         new_ent;

    always_comb begin
        new_ent.valid = 1'b1;
        new_ent.lock  = cmd_lock;
        new_ent.vpn   = cmd_vpn;
        new_ent.pfn   = cmd_pfn;
        new_ent.perm  = cmd_perm;
        wr_en   = 1'b0;
        wr_idx  = '0;
        clr_vec = '0;
        err_d   = err_q;
        rr_d    = rr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    unique case (op)
                        OP_WRITE_AUTO: begin
                            if (c_found) begin
                                wr_en  = 1'b1;
                                wr_idx = c_idx;
                                err_d  = 1'b0;
                            end else if (v_found) begin
                                wr_en  = 1'b1;
                                wr_idx = v_idx;
                                err_d  = 1'b0;
                                rr_d   = (v_idx == LAST) ? '0 : v_idx + 1'b1;
                            end else begin
                                err_d  = 1'b1;
                            end
                        end
                        OP_WRITE_AT: begin
                            wr_en   = 1'b1;
                            wr_idx  = cmd_idx;
                            clr_vec = c_hits;
                            err_d   = 1'b0;
                        end
                        OP_DROP_ONE: clr_vec = c_hits;
                        OP_FLUSH:    ;
                    endcase
                end
            end
            ST_SWEEP: clr_vec[sweep_q] = !lock_vec[sweep_q];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ent_q[i] <= '0;
            rr_q    <= '0;
            err_q   <= 1'b0;
            sweep_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (clr_vec[i]) begin
                    ent_q[i].valid <= 1'b0;
                    ent_q[i].lock  <= 1'b0;
                end
                if (wr_en && wr_idx == IDX_W'(i)) ent_q[i] <= new_ent;
            end
            rr_q    <= rr_d;
            err_q   <= err_d;
            sweep_q <= (state_q == ST_SWEEP) ? sweep_q + 1'b1 : '0;
        end
    end

    // R7: never two entries answering one page
    a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $onehot0(lk_hits));

    // R5: the replacement picker never hands back a pinned slot
    a_r5_victim_unpinned: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == OP_WRITE_AUTO && !c_found && v_found) |-> !lock_vec[v_idx]);

    // R6: refused write leaves the array untouched and flags it
    a_r6_refuse_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == OP_WRITE_AUTO && !c_found && !v_found)
        |=> (valid_vec == $past(valid_vec) && wr_err));

    // R9: dropped page is gone next cycle
    a_r9_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == OP_DROP_ONE) |=> ((valid_vec & $past(c_hits)) == '0));

    // R10: sweep end leaves only pinned entries
    a_r10_sweep_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_SWEEP && state_q == ST_IDLE)
        |-> ((valid_vec & ~lock_vec) == '0));

    // R10: no unpinned hit while sweeping
    a_r10_sweep_hides: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWEEP && lk_hit) |-> lock_vec[lk_idx]);
endmodule

// File: tb/soft_tlb_test.sv
`timescale 1ns/1ps
module soft_tlb_test;
    localparam int N = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0] lk_acc = '0;
    logic lk_hit, miss_trap, prot_trap, cmd_ready, wr_err;
    logic [31:0] lk_paddr;
    logic [19:0] miss_vpn;
    logic cmd_valid = 1'b0, cmd_lock = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [3:0] cmd_idx = '0;
    logic [19:0] cmd_vpn = '0, cmd_pfn = '0;
    logic [2:0] cmd_perm = '0;

    int n_tests = 0, n_fail = 0;

    // reference state built from the requirements
    bit          m_v[N], m_l[N];
    logic [19:0] m_vpn[N], m_pfn[N];
    logic [2:0]  m_perm[N];
    int          m_rr = 0;
    bit          m_err = 0;

    always #10 clk = ~clk;

    soft_tlb #(.N(N)) uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_acc(lk_acc), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
        .miss_trap(miss_trap), .miss_vpn(miss_vpn), .prot_trap(prot_trap),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_vpn(cmd_vpn), .cmd_pfn(cmd_pfn), .cmd_perm(cmd_perm),
        .cmd_lock(cmd_lock), .cmd_ready(cmd_ready), .wr_err(wr_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int m_find(input logic [19:0] vpn);
        for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    task automatic m_put(input int i, input logic [19:0] vpn, input logic [19:0] pfn,
                         input logic [2:0] perm, input bit lock);
        m_v[i] = 1; m_l[i] = lock; m_vpn[i] = vpn; m_pfn[i] = pfn; m_perm[i] = perm;
    endtask

    task automatic issue(input logic [1:0] op, input int idx, input logic [19:0] vpn,
                         input logic [19:0] pfn, input logic [2:0] perm, input bit lock);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_idx = 4'(idx); cmd_vpn = vpn;
        cmd_pfn = pfn; cmd_perm = perm; cmd_lock = lock;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic auto_wr(input logic [19:0] vpn, input logic [19:0] pfn, input logic [2:0] perm, input bit lock);
        int f, vic;
        issue(2'd0, 0, vpn, pfn, perm, lock);
        f = m_find(vpn);
        if (f >= 0) begin m_put(f, vpn, pfn, perm, lock); m_err = 0; end
        else begin
            vic = -1;
            for (int k = 0; k < N; k++) if (vic < 0 && !m_l[(m_rr + k) % N]) vic = (m_rr + k) % N;
            if (vic < 0) m_err = 1;
            else begin m_put(vic, vpn, pfn, perm, lock); m_rr = (vic + 1) % N; m_err = 0; end
        end
    endtask

    task automatic at_wr(input int idx, input logic [19:0] vpn, input logic [19:0] pfn, input logic [2:0] perm, input bit lock);
        int f;
        issue(2'd1, idx, vpn, pfn, perm, lock);
        f = m_find(vpn);
        if (f >= 0) begin m_v[f] = 0; m_l[f] = 0; end
        m_put(idx, vpn, pfn, perm, lock);
        m_err = 0;
    endtask

    task automatic drop(input logic [19:0] vpn);
        int f;
        issue(2'd2, 0, vpn, 0, 0, 0);
        f = m_find(vpn);
        if (f >= 0) begin m_v[f] = 0; m_l[f] = 0; end
    endtask

    task automatic look(input logic [19:0] vpn, input logic [11:0] off, input int acc, input string req);
        int f;
        bit e_hit, e_miss, e_prot, ok;
        logic [31:0] e_pa;
        lk_valid = 1; lk_vaddr = {vpn, off}; lk_acc = 2'(acc);
        #1;
        f = m_find(vpn);
        e_hit = 0; e_miss = 0; e_prot = 0; e_pa = '0;
        if (f < 0) e_miss = 1;
        else begin
            ok = (acc == 1) ? m_perm[f][1] : (acc == 2) ? m_perm[f][2] : m_perm[f][0];
            e_hit = ok; e_prot = !ok;
            if (ok) e_pa = {m_pfn[f], off};
        end
        chk({lk_hit, miss_trap, prot_trap, lk_paddr, miss_vpn} == {e_hit, e_miss, e_prot, e_pa, vpn},
            req, {9'b0, lk_hit, miss_trap, prot_trap, lk_paddr, miss_vpn},
            {9'b0, e_hit, e_miss, e_prot, e_pa, vpn});
        lk_valid = 0;
    endtask

    initial begin
        #(20 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_l[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0; m_perm[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready && !wr_err, "R1 reset ready/err", {cmd_ready, wr_err}, 2'b10);
        for (int v = 0; v < 4; v++) look(20'(v * 1000), 12'h123, v, "R1 R3 miss after reset");
        #1; lk_valid = 0; #1;
        chk({lk_hit, miss_trap, prot_trap} == 3'b000, "R3 idle flags", {lk_hit, miss_trap, prot_trap}, 0);

        // R5 fill in round-robin order, R2/R4 sweep every entry and access kind
        for (int i = 0; i < N; i++) auto_wr(20'h00100 + 20'(i * 37), 20'h80000 ^ 20'(i * 4099), 3'((i % 7) + 1), 0);
        for (int i = 0; i < N; i++)
            for (int a = 0; a < 4; a++)
                look(20'h00100 + 20'(i * 37), 12'((i * 291 + a * 5) & 12'hFFF), a, "R2 R4 R5 translate");

        // R5 wrap: next new page evicts slot 0
        auto_wr(20'hABCDE, 20'h12345, 3'b111, 0);
        look(20'h00100, 12'h010, 0, "R5 evicted slot 0");
        look(20'hABCDE, 12'hFFF, 1, "R5 wrapped write");

        // R7 overwrite on match, then R9 drop proves single copy
        auto_wr(20'h00100 + 20'(5 * 37), 20'h0BEEF, 3'b111, 0);
        look(20'h00100 + 20'(5 * 37), 12'h444, 2, "R7 overwrite");
        drop(20'h00100 + 20'(5 * 37));
        look(20'h00100 + 20'(5 * 37), 12'h444, 0, "R7 R9 gone after drop");
        auto_wr(20'h55555, 20'h66666, 3'b001, 0);
        look(20'h00100 + 20'(1 * 37), 12'h0, 0, "R5 R7 pointer kept");
        look(20'h55555, 12'h0, 0, "R5 next victim");

        // R8 indexed writes with mixed pinning
        for (int i = 0; i < N; i++) at_wr(i, 20'h20000 + 20'(i), 20'h40000 + 20'(i * 3), 3'b011, (i % 3) == 0);
        at_wr(7, 20'h20008, 20'h7ABCD, 3'b101, 0);
        for (int i = 0; i < N; i++) look(20'h20000 + 20'(i), 12'hABC, 0, "R8 indexed");
        at_wr(0, 20'h2F000, 20'h11111, 3'b001, 0);
        look(20'h20000, 12'h0, 0, "R8 pinned slot overwritten");
        look(20'h2F000, 12'h0, 0, "R8 pinned slot overwritten");

        // R10 flush sweep, R11 command ignored while busy
        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'd3;
        @(negedge clk);
        cmd_valid = 0;
        for (int i = 0; i < N; i++) if (!m_l[i]) m_v[i] = 0;
        chk(!cmd_ready, "R10 busy after flush", cmd_ready, 0);
        look(20'h20003, 12'h1, 0, "R10 pinned visible in sweep");
        look(20'h20001, 12'h1, 0, "R10 unpinned hidden in sweep");
        cmd_valid = 1; cmd_op = 2'd0; cmd_vpn = 20'h07777; cmd_pfn = 20'h1; cmd_perm = 3'b111; cmd_lock = 0;
        cnt = 1;
        @(negedge clk);
        cmd_valid = 0;
        while (!cmd_ready && cnt < 100) begin cnt++; @(negedge clk); end
        chk(cnt == N, "R10 sweep length", 64'(cnt), 64'(N));
        for (int i = 0; i < N; i++) look(20'h20000 + 20'(i), 12'h777, 0, "R10 after flush");
        look(20'h07777, 12'h0, 0, "R11 ignored while busy");

        // R6 all pinned refuses, R9 drop pinned frees a slot
        for (int i = 0; i < N; i++) at_wr(i, 20'h30000 + 20'(i), 20'h50000 + 20'(i), 3'b111, 1);
        auto_wr(20'h44444, 20'h99999, 3'b111, 0);
        chk(wr_err == m_err && m_err, "R6 refuse flag", wr_err, 1);
        look(20'h44444, 12'h0, 0, "R6 refused page absent");
        for (int i = 0; i < N; i++) look(20'h30000 + 20'(i), 12'h5, 1, "R6 entries intact");
        drop(20'h30003);
        look(20'h30003, 12'h0, 0, "R9 pinned dropped");
        chk(wr_err == 1, "R6 flag held", wr_err, 1);
        auto_wr(20'h44444, 20'h99999, 3'b111, 0);
        chk(wr_err == 0, "R6 flag cleared", wr_err, 0);
        look(20'h44444, 12'hFED, 2, "R6 R9 freed slot used");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule